// File: doc/BRIEF.md
# Wide-Mode Branch Target Unit

This unit resolves branch instructions issued while a dual-instruction-set processor runs in its 32-bit instruction state. It receives the 32-bit opcode, the program counter value (which already reads ahead of the instruction being executed) and an execute strobe. One cycle after the strobe it presents four results: the branch destination, an optional value for the link register, a request to switch the core into its 16-bit compressed instruction state, and a pipeline flush pulse.

Three forms are handled. The plain branch only redirects the program counter. The branch with link also saves a return address. The immediate branch-with-exchange form is chosen by an all-ones condition field. In that form the link bit changes role and becomes bit 1 of the offset, so halfword-aligned destinations can be reached. Condition evaluation for ordinary branches happens upstream, so the strobe is only raised for branches that are taken. The register file and fetch logic take the outputs from here.

Top module: `wide_branch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, flush_o, lr_wr_o and narrow_set_o are 0 and pc_new_o and lr_data_o are zero.
- R2: Opcode bits 31:28 equal to 4'b1111 select the exchange form. Any other value selects the ordinary form, with bit 24 as its link flag.
- R3: In the ordinary form, pc_new_o equals pc_i plus the 24-bit immediate in bits 23:0, sign-extended and shifted left by 2, with the sum wrapping modulo 2^32.
- R4: In the ordinary form, bit 24 set raises lr_wr_o with lr_data_o equal to pc_i minus 4 (wrapping modulo 2^32). Bit 24 clear leaves lr_wr_o low and lr_data_o zero.
- R5: In the exchange form, pc_new_o equals pc_i plus an offset. The offset is the sign-extended immediate shifted left by 2, with bit 24 of the opcode placed at bit 1. The sum wraps modulo 2^32.
- R6: In the exchange form, lr_wr_o is raised with lr_data_o equal to pc_i minus 4, whatever the value of bit 24.
- R7: narrow_set_o pulses with the result of every exchange-form branch and stays low for ordinary branches.
- R8: flush_o is high for exactly one cycle per strobe. In any cycle that does not follow a strobe, all strobes are low and pc_new_o and lr_data_o read zero.
- R9: Results appear in the cycle after the strobe. Strobes on consecutive cycles each produce their own results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe for a taken branch |
| opcode_i | input | 32 | Branch instruction word |
| pc_i | input | 32 | Program counter as read during execute |
| flush_o | output | 1 | One-cycle flush/refill request; also qualifies pc_new_o |
| pc_new_o | output | 32 | Branch destination |
| lr_wr_o | output | 1 | Link register write enable |
| lr_data_o | output | 32 | Value for the link register |
| narrow_set_o | output | 1 | Switch to the 16-bit compressed instruction state |

## Verification
The hardest cases to reach are the ones where the exchange form's halfword bit interacts with a sign-extended negative offset and with wraparound at the 32-bit boundary. A wrong OR or a dropped bit shows up only for certain offset and program counter pairs. The stimulus table pairs extreme immediates (all ones, the most negative value, the largest positive value) with program counter values near zero and near 2^32. Each form is run with bit 24 both set and clear. A back-to-back strobe pair checks that one result does not leak into the next.

// File: rtl/wbu_pkg.sv
package wbu_pkg;

   typedef enum logic [1:0] {
      BK_PLAIN = 2'd0,
      BK_LINK  = 2'd1,
      BK_XCHG  = 2'd2
   } br_kind_e;

   localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/wbu_decode.sv
module wbu_decode
   import wbu_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned IMM_W  = 24,
   parameter int unsigned COND_W = 4
) (
   input  logic [XLEN-1:0]  opcode_i,
   output br_kind_e         kind_o,
   output logic [IMM_W-1:0] imm_o,
   output logic             half_o
);

   localparam int unsigned LINK_POS = IMM_W;
   localparam int unsigned COND_LSB = XLEN - COND_W;

   if (LINK_POS >= COND_LSB) begin : g_bad_layout
      $error("wbu_decode: link bit overlaps condition field");
   end

   logic [COND_W-1:0] cond;
   logic              xchg;
   logic              link_bit;

   assign cond     = opcode_i[XLEN-1:COND_LSB];
   assign xchg     = &cond;
   assign link_bit = opcode_i[LINK_POS];
   assign imm_o    = opcode_i[IMM_W-1:0];

   always_comb begin
      if (xchg) begin
         kind_o = BK_XCHG;
      end else if (link_bit) begin
         kind_o = BK_LINK;
      end else begin
         kind_o = BK_PLAIN;
      end
   end

   // In the exchange form the link bit becomes the halfword offset bit
   assign half_o = xchg & link_bit;

endmodule

// File: rtl/wbu_calc.sv
module wbu_calc
   import wbu_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned IMM_W    = 24,
   parameter int unsigned LINK_ADJ = 4
) (
   input  br_kind_e         kind_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             half_i,
   input  logic [XLEN-1:0]  pc_i,
   output logic [XLEN-1:0]  target_o,
   output logic [XLEN-1:0]  link_o
);

   localparam int unsigned SH_W  = IMM_W + WORD_SHIFT;
   localparam int unsigned EXT_W = (XLEN > SH_W) ? XLEN - SH_W : 1;

   if (SH_W > XLEN) begin : g_bad_width
      $error("wbu_calc: shifted immediate wider than datapath");
   end

   logic [SH_W-1:0] shifted;
   logic [XLEN-1:0] base_off;
   logic [XLEN-1:0] half_off;
   logic [XLEN-1:0] offset;

   assign shifted = {imm_i, {WORD_SHIFT{1'b0}}};

   if (XLEN > SH_W) begin : g_sext
      assign base_off = {{EXT_W{shifted[SH_W-1]}}, shifted};
   end else begin : g_noext
      assign base_off = shifted[XLEN-1:0];
   end

   always_comb begin
      half_off    = '0;
      half_off[1] = half_i;
   end

   assign offset   = (kind_i == BK_XCHG) ? (base_off | half_off) : base_off;
   assign target_o = pc_i + offset;
   assign link_o   = pc_i - XLEN'(LINK_ADJ);

endmodule

// File: rtl/wbu_outreg.sv
module wbu_outreg
   import wbu_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exec_i,
   input  br_kind_e        kind_i,
   input  logic [XLEN-1:0] target_i,
   input  logic [XLEN-1:0] link_i,
   output logic            flush_o,
   output logic [XLEN-1:0] pc_new_o,
   output logic            lr_wr_o,
   output logic [XLEN-1:0] lr_data_o,
   output logic            narrow_set_o
);

   logic wants_link;
   assign wants_link = exec_i & (kind_i != BK_PLAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_o      <= 1'b0;
         lr_wr_o      <= 1'b0;
         narrow_set_o <= 1'b0;
      end else begin
         flush_o      <= exec_i;
         lr_wr_o      <= wants_link;
         narrow_set_o <= exec_i & (kind_i == BK_XCHG);
      end
   end

   if (IDLE_ZERO) begin : g_idle_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_new_o  <= '0;
            lr_data_o <= '0;
         end else begin
            pc_new_o  <= exec_i ? target_i : '0;
            lr_data_o <= wants_link ? link_i : '0;
         end
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_new_o  <= '0;
            lr_data_o <= '0;
         end else begin
            if (exec_i) begin
               pc_new_o <= target_i;
            end
            if (wants_link) begin
               lr_data_o <= link_i;
            end
         end
      end
   end

endmodule

// File: rtl/wide_branch_unit.sv
module wide_branch_unit
   import wbu_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned IMM_W     = 24,
   parameter int unsigned COND_W    = 4,
   parameter int unsigned LINK_ADJ  = 4,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exec_i,
   input  logic [XLEN-1:0] opcode_i,
   input  logic [XLEN-1:0] pc_i,
   output logic            flush_o,
   output logic [XLEN-1:0] pc_new_o,
   output logic            lr_wr_o,
   output logic [XLEN-1:0] lr_data_o,
   output logic            narrow_set_o
);

   if (COND_W == 0 || COND_W >= XLEN) begin : g_bad_cond
      $error("wide_branch_unit: illegal condition field width");
   end

   br_kind_e         kind;
   logic [IMM_W-1:0] imm;
   logic             half;
   logic [XLEN-1:0]  target;
   logic [XLEN-1:0]  link;

   wbu_decode #(
      .XLEN   (XLEN),
      .IMM_W  (IMM_W),
      .COND_W (COND_W)
   ) decode_i (
      .opcode_i (opcode_i),
      .kind_o   (kind),
      .imm_o    (imm),
      .half_o   (half)
   );

   wbu_calc #(
      .XLEN     (XLEN),
      .IMM_W    (IMM_W),
      .LINK_ADJ (LINK_ADJ)
   ) calc_i (
      .kind_i   (kind),
      .imm_i    (imm),
      .half_i   (half),
      .pc_i     (pc_i),
      .target_o (target),
      .link_o   (link)
   );

   wbu_outreg #(
      .XLEN      (XLEN),
      .IDLE_ZERO (IDLE_ZERO)
   ) outreg_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec_i       (exec_i),
      .kind_i       (kind),
      .target_i     (target),
      .link_i       (link),
      .flush_o      (flush_o),
      .pc_new_o     (pc_new_o),
      .lr_wr_o      (lr_wr_o),
      .lr_data_o    (lr_data_o),
      .narrow_set_o (narrow_set_o)
   );

endmodule

// File: rtl/wbu_chk.sv
module wbu_chk #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned IMM_W    = 24,
   parameter int unsigned COND_W   = 4,
   parameter int unsigned LINK_ADJ = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exec_i,
   input logic [XLEN-1:0] opcode_i,
   input logic [XLEN-1:0] pc_i,
   input logic            flush_o,
   input logic [XLEN-1:0] pc_new_o,
   input logic            lr_wr_o,
   input logic [XLEN-1:0] lr_data_o,
   input logic            narrow_set_o
);

   logic is_xchg;
   assign is_xchg = &opcode_i[XLEN-1 -: COND_W];

   // R8
   flush_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i |=> flush_o);

   // R8
   no_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> (!flush_o && !lr_wr_o && !narrow_set_o));

   // R7
   narrow_implies_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      narrow_set_o |-> (lr_wr_o && flush_o));

   // R2
   xchg_sets_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && is_xchg) |=> narrow_set_o);

   // R6
   xchg_link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && is_xchg) |=> (lr_wr_o && lr_data_o == $past(pc_i) - XLEN'(LINK_ADJ)));

   // R4
   plain_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && !is_xchg && !opcode_i[IMM_W]) |=> (!lr_wr_o && !narrow_set_o));

   // R3
   plain_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && !is_xchg) |=>
         (pc_new_o == $past(pc_i) +
            {{(XLEN-IMM_W-2){$past(opcode_i[IMM_W-1])}}, $past(opcode_i[IMM_W-1:0]), 2'b00}));

endmodule

bind wide_branch_unit wbu_chk #(
   .XLEN     (XLEN),
   .IMM_W    (IMM_W),
   .COND_W   (COND_W),
   .LINK_ADJ (LINK_ADJ)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .exec_i       (exec_i),
   .opcode_i     (opcode_i),
   .pc_i         (pc_i),
   .flush_o      (flush_o),
   .pc_new_o     (pc_new_o),
   .lr_wr_o      (lr_wr_o),
   .lr_data_o    (lr_data_o),
   .narrow_set_o (narrow_set_o)
);

// File: tb/wide_branch_unit_tb_top.sv
module wide_branch_unit_tb_top;

   typedef struct packed {
      logic [3:0]  cond;
      logic        lbit;
      logic [23:0] imm;
      logic [31:0] pc;
      logic [31:0] exp_pc;
      logic        exp_lw;
      logic [31:0] exp_lr;
      logic        exp_t;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{4'hE, 1'b0, 24'h000010, 32'h00001000, 32'h00001040, 1'b0, 32'h00000000, 1'b0},
      '{4'h0, 1'b1, 24'hFFFFFF, 32'h00002000, 32'h00001FFC, 1'b1, 32'h00001FFC, 1'b0},
      '{4'hA, 1'b0, 24'h000001, 32'hFFFFFFFC, 32'h00000000, 1'b0, 32'h00000000, 1'b0},
      '{4'hE, 1'b1, 24'h800000, 32'h01000000, 32'hFF000000, 1'b1, 32'h00FFFFFC, 1'b0},
      '{4'hF, 1'b0, 24'h000004, 32'h00008000, 32'h00008010, 1'b1, 32'h00007FFC, 1'b1},
      '{4'hF, 1'b1, 24'h000004, 32'h00008000, 32'h00008012, 1'b1, 32'h00007FFC, 1'b1},
      '{4'hF, 1'b1, 24'hFFFFFE, 32'h00000100, 32'h000000FA, 1'b1, 32'h000000FC, 1'b1},
      '{4'hF, 1'b0, 24'h7FFFFF, 32'hFE000004, 32'h00000000, 1'b1, 32'hFE000000, 1'b1},
      '{4'h1, 1'b1, 24'h000000, 32'h00000002, 32'h00000002, 1'b1, 32'hFFFFFFFE, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [31:0] opcode_i = '0;
   logic [31:0] pc_i = '0;
   logic        flush_o;
   logic [31:0] pc_new_o;
   logic        lr_wr_o;
   logic [31:0] lr_data_o;
   logic        narrow_set_o;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   wide_branch_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec_i       (exec_i),
      .opcode_i     (opcode_i),
      .pc_i         (pc_i),
      .flush_o      (flush_o),
      .pc_new_o     (pc_new_o),
      .lr_wr_o      (lr_wr_o),
      .lr_data_o    (lr_data_o),
      .narrow_set_o (narrow_set_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      opcode_i = {v.cond, 3'b101, v.lbit, v.imm};
      pc_i     = v.pc;
      exec_i   = 1'b1;
   endtask

   task automatic check_result(input vec_t v);
      bit xf;
      xf = (v.cond == 4'hF);
      chk(xf ? "R5 target" : "R3 target", pc_new_o, v.exp_pc);
      chk(xf ? "R6 link enable" : "R4 link enable", {31'd0, lr_wr_o}, {31'd0, v.exp_lw});
      chk(xf ? "R6 link value" : "R4 link value", lr_data_o, v.exp_lr);
      chk("R2 R7 state switch", {31'd0, narrow_set_o}, {31'd0, v.exp_t});
      chk("R9 flush with result", {31'd0, flush_o}, 32'd1);
   endtask

   task automatic check_idle();
      chk("R8 flush idle", {31'd0, flush_o}, 32'd0);
      chk("R8 link idle", {31'd0, lr_wr_o}, 32'd0);
      chk("R8 state idle", {31'd0, narrow_set_o}, 32'd0);
      chk("R8 target idle", pc_new_o, 32'd0);
      chk("R8 link data idle", lr_data_o, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

   initial begin
      // R1: outputs during reset
      repeat (3) @(negedge clk);
      chk("R1 flush in reset", {31'd0, flush_o}, 32'd0);
      chk("R1 target in reset", pc_new_o, 32'd0);
      chk("R1 link in reset", {31'd0, lr_wr_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle();

      // Table walk: each vector followed by an idle cycle
      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         exec_i = 1'b0;
         check_result(VECS[i]);
         @(negedge clk);
         check_idle();
      end

      // R9: back-to-back strobes, plain then exchange
      drive(VECS[0]);
      @(negedge clk);
      drive(VECS[5]);
      check_result(VECS[0]);
      @(negedge clk);
      exec_i = 1'b0;
      check_result(VECS[5]);
      @(negedge clk);
      check_idle();

      // R9: exchange then ordinary link, no leakage of the state bit
      drive(VECS[6]);
      @(negedge clk);
      drive(VECS[1]);
      check_result(VECS[6]);
      @(negedge clk);
      exec_i = 1'b0;
      check_result(VECS[1]);

      // R1: reset while a result is on the outputs
      drive(VECS[4]);
      @(negedge clk);
      exec_i = 1'b0;
      rst_n  = 1'b0;
      #1;
      chk("R1 async reset flush", {31'd0, flush_o}, 32'd0);
      chk("R1 async reset state", {31'd0, narrow_set_o}, 32'd0);
      chk("R1 async reset link", lr_data_o, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

endmodule